// File: doc/BRIEF.md
# Programmable Input Delay Pulse Filter

This block screens four capture inputs before they reach edge detection. Each raw pin is brought into the bus clock domain through a two-flop synchronizer. A level change is then accepted only once the synchronized value has disagreed with the currently accepted level for a programmed number of consecutive bus cycles. Any excursion that ends sooner is dropped, whether it goes high or low. Every accepted change raises a one-cycle rising or falling strobe for the downstream capture logic.

All four channels share one hold-time setting, and each channel has its own counter. A setting of zero turns the filter off, so the synchronized level passes straight through. Sampling is aligned to the bus clock, so the accept threshold is an exact cycle count: an excursion held for `dly_i` sampled cycles passes, and one held for one cycle fewer does not.

Top module: `glitch_hold_filter`

## Requirements
- R1: The four channels are filtered independently with one shared setting `dly_i`; stimulus on one channel never moves another channel's level or strobes.
- R2: With `dly_i` = D > 0, an excursion of the pin lasting D-1 bus cycles or fewer is rejected: `lvl_o` keeps its level and neither strobe fires.
- R3: With `dly_i` = D > 0, an excursion lasting D bus cycles or more is accepted; for example, with D = 256 a 255-cycle pulse is rejected and a 256-cycle pulse is accepted.
- R4: Filtering treats both polarities alike: a high pulse on a low line and a low pulse on a high line follow the same accept/reject rule.
- R5: After a pin change that is held, `lvl_o` changes exactly max(D,1)+2 rising clock edges later (two synchronizer stages plus the hold count).
- R6: With `dly_i` = 0 the filter is bypassed: every synchronized change, even a single-cycle pulse, reaches `lvl_o`.
- R7: `rise_o[c]` is high for exactly one cycle when `lvl_o[c]` goes from 0 to 1, `fall_o[c]` for exactly one cycle when it goes from 1 to 0, and the two are never high together.
- R8: While `rst_ni` is low, all filtered levels, strobes and counters are zero.
- R9: Any single sampled cycle in which the input agrees with the accepted level restarts that channel's count, so two sub-threshold runs separated by a one-cycle gap are rejected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_i | input | 4 | Raw capture pins, one bit per channel |
| dly_i | input | 9 | Hold-time setting in bus cycles, 0 bypasses the filter |
| lvl_o | output | 4 | Filtered pin levels |
| rise_o | output | 4 | One-cycle strobe on an accepted 0-to-1 change |
| fall_o | output | 4 | One-cycle strobe on an accepted 1-to-0 change |

## Verification
For every setting from 0 to 7, pulse lengths are swept from one cycle up to two cycles past the threshold, in both polarities and rotating across channels. This sweep separates an off-by-one in the threshold from a fault in the polarity handling. Step inputs then measure the exact latency per setting, and the 255/256 pair at a setting of 256 checks the full counter width. A gapped pulse checks that the count restarts instead of pausing, and four simultaneous pulses of different lengths show that the channel counters do not share state.

// File: rtl/dlyflt_pkg.sv
package dlyflt_pkg;

  localparam int NUM_CH_DEF = 4;
  localparam int DLY_W_DEF  = 9;

  // Hold window is complete once the run count reaches setting-1.
  function automatic logic hold_reached(input int unsigned run_cnt,
                                        input int unsigned setting);
    return (setting != 0) && (run_cnt + 1 >= setting);
  endfunction

  // Rising edges from a held pin change to the filtered level change.
  function automatic int unsigned filter_latency(input int unsigned setting,
                                                 input int unsigned sync_depth);
    return sync_depth + ((setting == 0) ? 1 : setting);
  endfunction

endpackage

// File: rtl/dlyflt_sync.sv
module dlyflt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_i,
  output logic smp_o
);
  logic [STAGES-1:0] stage_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_q <= '0;
    else         stage_q <= {stage_q[STAGES-2:0], raw_i};
  end

  assign smp_o = stage_q[STAGES-1];

  assert_sync_latency_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(rst_ni, 2)) |-> (smp_o == $past(raw_i, 2)));
endmodule

// File: rtl/dlyflt_chan.sv
module dlyflt_chan #(
  parameter int DLY_W = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             smp_i,
  input  logic [DLY_W-1:0] dly_i,
  output logic             lvl_o,
  output logic             upd_o
);
  import dlyflt_pkg::*;

  logic [DLY_W-1:0] cnt_q;
  logic             lvl_q;
  logic             differ;
  logic             bypass;
  logic             done;

  assign differ = (smp_i != lvl_q);
  assign bypass = (dly_i == '0);
  assign done   = hold_reached(int'(cnt_q), int'(dly_i));
  assign upd_o  = differ && (bypass || done);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      lvl_q <= 1'b0;
    end else if (upd_o) begin
      lvl_q <= smp_i;
      cnt_q <= '0;
    end else if (differ) begin
      cnt_q <= cnt_q + 1'b1;
    end else begin
      cnt_q <= '0;
    end
  end

  assign lvl_o = lvl_q;

  assert_cnt_below_setting_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && ($past(dly_i) == dly_i) && (dly_i != '0)) |-> (cnt_q < dly_i));

  assert_change_after_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && (lvl_q != $past(lvl_q)) && ($past(dly_i) != '0))
      |-> (int'($past(cnt_q)) + 1 >= int'($past(dly_i))));

  assert_bypass_follows_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && ($past(dly_i) == '0)) |-> (lvl_q == $past(smp_i)));

  assert_restart_on_agree_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && ($past(smp_i) == $past(lvl_q))) |-> (cnt_q == '0));
endmodule

// File: rtl/dlyflt_edge.sv
module dlyflt_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic rise_o,
  output logic fall_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~prev_q;
  assign fall_o = ~lvl_i & prev_q;

  assert_rise_one_cycle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
  assert_fall_one_cycle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |=> !fall_o);
  assert_strobes_exclusive_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rise_o && fall_o));
endmodule

// File: rtl/glitch_hold_filter.sv
module glitch_hold_filter #(
  parameter int NUM_CH     = dlyflt_pkg::NUM_CH_DEF,
  parameter int DLY_W      = dlyflt_pkg::DLY_W_DEF,
  parameter int SYNC_DEPTH = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] pin_i,
  input  logic [DLY_W-1:0]  dly_i,
  output logic [NUM_CH-1:0] lvl_o,
  output logic [NUM_CH-1:0] rise_o,
  output logic [NUM_CH-1:0] fall_o
);
  logic [NUM_CH-1:0] smp_w;
  logic [NUM_CH-1:0] upd_w;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    dlyflt_sync #(.STAGES(SYNC_DEPTH)) u_sync (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .raw_i (pin_i[c]),
      .smp_o (smp_w[c])
    );

    dlyflt_chan #(.DLY_W(DLY_W)) u_chan (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .smp_i (smp_w[c]),
      .dly_i (dly_i),
      .lvl_o (lvl_o[c]),
      .upd_o (upd_w[c])
    );

    dlyflt_edge u_edge (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .lvl_i (lvl_o[c]),
      .rise_o(rise_o[c]),
      .fall_o(fall_o[c])
    );

    assert_strobe_needs_update_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(rst_ni) && (rise_o[c] || fall_o[c]) |-> $past(upd_w[c]));
  end

  assert_reset_quiet_R8: assert property (@(posedge clk_i)
    !rst_ni |-> (lvl_o == '0 && rise_o == '0 && fall_o == '0));
endmodule

// File: tb/test_glitch_hold_filter.sv
module test_glitch_hold_filter;
  localparam int NCH = 4;
  localparam int DW  = 9;

  logic           clk;
  logic           rst_n;
  logic [NCH-1:0] pin;
  logic [DW-1:0]  dly;
  logic [NCH-1:0] lvl, rise, fall;

  int n_chk  = 0;
  int n_fail = 0;
  int rcnt [NCH];
  int fcnt [NCH];
  bit finished = 0;

  glitch_hold_filter i_glitch_hold_filter (
    .clk_i(clk), .rst_ni(rst_n), .pin_i(pin), .dly_i(dly),
    .lvl_o(lvl), .rise_o(rise), .fall_o(fall)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(negedge clk) begin
    for (int c = 0; c < NCH; c++) begin
      if (rst_n && rise[c]) rcnt[c] = rcnt[c] + 1;
      if (rst_n && fall[c]) fcnt[c] = fcnt[c] + 1;
    end
  end

  function automatic int exp_latency(input int d);
    return (d < 1 ? 1 : d) + 2;
  endfunction

  function automatic bit exp_accept(input int d, input int p);
    return (d == 0) || (p >= d);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  // One pulse of length p on channel ch; pol is the pulse level.
  task automatic pulse(input int ch, input bit pol, input int p, input int d, input string req);
    int r0 [NCH];
    int f0 [NCH];
    bit acc;
    dly = DW'(d);
    pin = {NCH{~pol}};
    cyc(d + 12);
    for (int c = 0; c < NCH; c++) begin r0[c] = rcnt[c]; f0[c] = fcnt[c]; end
    pin[ch] = pol;
    cyc(p);
    pin[ch] = ~pol;
    cyc(d + 12);
    acc = exp_accept(d, p);
    check(rcnt[ch] - r0[ch] == int'(acc), req, rcnt[ch] - r0[ch], int'(acc));
    check(fcnt[ch] - f0[ch] == int'(acc), req, fcnt[ch] - f0[ch], int'(acc));
    check(lvl[ch] == ~pol, req, lvl[ch], ~pol);
    for (int c = 0; c < NCH; c++)
      if (c != ch)
        check(rcnt[c] == r0[c] && fcnt[c] == f0[c], "R1 quiet neighbour",
              rcnt[c] - r0[c] + fcnt[c] - f0[c], 0);
  endtask

  task automatic step_latency(input int ch, input int d);
    int n;
    dly = DW'(d);
    pin = '0;
    cyc(d + 12);
    pin[ch] = 1'b1;
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!lvl[ch] && n < d + 30);
    check(n == exp_latency(d), "R5 latency", n, exp_latency(d));
    check(rise[ch] == 1'b1, "R7 rise strobe", rise[ch], 1);
    @(negedge clk);
    check(rise[ch] == 1'b0, "R7 rise one cycle", rise[ch], 0);
    pin[ch] = 1'b0;
    cyc(d + 12);
  endtask

  initial begin
    #(200000 * 10);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    report();
  end

  initial begin
    for (int c = 0; c < NCH; c++) begin rcnt[c] = 0; fcnt[c] = 0; end
    rst_n = 1'b0;
    pin   = '1;
    dly   = DW'(3);
    cyc(4);
    check(lvl == '0 && rise == '0 && fall == '0, "R8 reset quiet",
          int'({lvl, rise, fall}), 0);
    pin = '0;
    cyc(2);
    rst_n = 1'b1;
    cyc(3);
    check(lvl == '0, "R8 after reset", int'(lvl), 0);

    // Pulse-length sweeps, both polarities, rotating channels.
    for (int d = 0; d <= 7; d++)
      for (int p = 1; p <= d + 2; p++) begin
        pulse(p % NCH, 1'b1, p, d, (d == 0) ? "R6 bypass high" :
              (p < d ? "R2 reject high" : "R3 accept high"));
        pulse((p + 1) % NCH, 1'b0, p, d, (d == 0) ? "R6 bypass low" :
              (p < d ? "R4 reject low" : "R4 accept low"));
      end

    // Full-width threshold.
    pulse(2, 1'b1, 255, 256, "R2 255 at 256");
    pulse(3, 1'b1, 256, 256, "R3 256 at 256");

    // Exact latency per setting.
    for (int d = 0; d <= 6; d++) step_latency(d % NCH, d);

    // Gapped pulse: the count must restart.
    begin
      int r0;
      dly = DW'(5);
      pin = '0;
      cyc(20);
      r0 = rcnt[1];
      pin[1] = 1'b1; cyc(4);
      pin[1] = 1'b0; cyc(1);
      pin[1] = 1'b1; cyc(4);
      pin[1] = 1'b0; cyc(20);
      check(rcnt[1] == r0 && lvl[1] == 1'b0, "R9 gap restarts count", rcnt[1] - r0, 0);
    end

    // Simultaneous channels with different lengths.
    begin
      int r0 [NCH];
      int plen [NCH];
      plen[0] = 3; plen[1] = 4; plen[2] = 6; plen[3] = 2;
      dly = DW'(4);
      pin = '0;
      cyc(20);
      for (int c = 0; c < NCH; c++) r0[c] = rcnt[c];
      pin = '1;
      for (int t = 1; t <= 6; t++) begin
        @(negedge clk);
        for (int c = 0; c < NCH; c++) if (t == plen[c]) pin[c] = 1'b0;
      end
      cyc(20);
      for (int c = 0; c < NCH; c++)
        check(rcnt[c] - r0[c] == int'(exp_accept(4, plen[c])), "R1 parallel channels",
              rcnt[c] - r0[c], int'(exp_accept(4, plen[c])));
    end

    // Falling strobe width.
    dly = DW'(2);
    pin = '1;
    cyc(20);
    pin[0] = 1'b0;
    cyc(exp_latency(2));
    check(fall[0] == 1'b1 && rise[0] == 1'b0, "R7 fall strobe", fall[0], 1);
    @(negedge clk);
    check(fall[0] == 1'b0, "R7 fall one cycle", fall[0], 0);

    report();
  end
endmodule